// File: doc/BRIEF.md
# Secured Configuration Access Controller

This block stands between the programming port of a small programmable logic device and that device's configuration store. It takes one command at a time. The commands write or read back configuration words, force single output registers to a chosen level for test set-up, write or read a user signature of eight bytes, lock the device, and bulk-erase it. The nonvolatile cells are modelled as ordinary flip-flops. Charge pumps and programming voltages are not modelled.

The lock is a one-way latch. It starts to act on the command that follows the one that set it. While it is set, configuration readback returns zeros and preload has no effect, and both raise a one-cycle `denied` pulse. The signature can still be read and written while the lock is set. Only a bulk erase clears the lock, and that erase also clears every configuration word but leaves the signature as it was. Every command that writes holds `busy` high for a fixed number of cycles, and the block ignores any command presented while `busy` is high.

Top module: `cfg_guard_ctrl`

## Requirements
- R1: After reset, `busy`, `secured`, `rd_valid` and `denied` are 0, `out_regs` is all zeros, and every configuration word and signature byte reads 0.
- R2: A command is taken when `cmd_valid` is 1 and `busy` is 0. The write opcodes are 1 (configuration write), 4 (signature write), 6 (lock) and 7 (bulk erase). Each of them holds `busy` high for exactly WR_CYCLES cycles, starting in the cycle after the command is taken. A command presented while `busy` is 1 has no effect.
- R3: Opcode 1 stores `cmd_wdata` in configuration word `cmd_addr`. Opcode 2 (verify) puts that word on `rd_data` with `rd_valid` high for one cycle, one cycle after the command is taken, provided the lock is clear.
- R4: Opcode 4 stores `cmd_wdata` in signature byte `cmd_addr`. Opcode 5 returns that byte on `rd_data` with `rd_valid` high one cycle later. Both work whether or not the lock is set, and neither raises `denied`.
- R5: Opcode 3 (preload) sets `out_regs[cmd_addr]` to `cmd_wdata[0]` one cycle after the command is taken, and leaves every other bit of `out_regs` unchanged.
- R6: Opcode 6 sets `secured` one cycle after the command is taken. `secured` then stays set until a bulk erase.
- R7: A verify taken while `secured` is 1 returns `rd_data` of 0 with `rd_valid` high, and `denied` is high for exactly that one cycle.
- R8: A preload taken while `secured` is 1 leaves `out_regs` unchanged and raises `denied` for one cycle.
- R9: Opcode 7 clears every configuration word and clears `secured`. It leaves every signature byte unchanged.
- R10: A write to an address beyond the configuration, signature or register range changes nothing. A read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | ADDR_W | Word, byte or register index |
| cmd_wdata | input | DATA_W | Write data; bit 0 is the preload level |
| busy | output | 1 | A write is in progress; commands are ignored |
| secured | output | 1 | The lock latch is set |
| rd_valid | output | 1 | `rd_data` holds a read result |
| rd_data | output | DATA_W | Read result |
| denied | output | 1 | One-cycle pulse when a verify or preload is refused |
| out_regs | output | REG_N | Output register state |

## Verification
The hardest states to reach from the ports are those that follow a lock. In them, a refused preload has to be told apart from one that is carried out, and the signature data written before the lock has to survive both the lock and a later bulk erase. The vector table first builds a known preload pattern and known signature contents. It then locks the device and replays verify, preload and signature commands against that known state. After that it erases and reads everything back. Separate directed tests count the cycles that `busy` stays high, present a command in the middle of a write, and check that `denied` falls after a single cycle.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

   typedef enum logic [2:0] {
      OP_IDLE    = 3'd0,
      OP_CFG_WR  = 3'd1,
      OP_CFG_VFY = 3'd2,
      OP_PRELOAD = 3'd3,
      OP_SIG_WR  = 3'd4,
      OP_SIG_RD  = 3'd5,
      OP_LOCK    = 3'd6,
      OP_ERASE   = 3'd7
   } guard_op_e;

   typedef struct packed {
      logic cfg_wr;
      logic cfg_vfy;
      logic preload;
      logic sig_wr;
      logic sig_rd;
      logic lock;
      logic erase;
   } guard_stb_t;

endpackage

// File: rtl/cfg_guard_decode.sv
module cfg_guard_decode
   import cfg_guard_pkg::*;
(
   input  logic       cmd_valid,
   input  logic [2:0] cmd_op,
   input  logic       busy,
   output guard_stb_t stb,
   output logic       timed_wr
);

   logic taken;
   assign taken = cmd_valid & ~busy;

   always_comb begin
      stb = '0;
      if (taken) begin
         case (guard_op_e'(cmd_op))
            OP_CFG_WR:  stb.cfg_wr  = 1'b1;
            OP_CFG_VFY: stb.cfg_vfy = 1'b1;
            OP_PRELOAD: stb.preload = 1'b1;
            OP_SIG_WR:  stb.sig_wr  = 1'b1;
            OP_SIG_RD:  stb.sig_rd  = 1'b1;
            OP_LOCK:    stb.lock    = 1'b1;
            OP_ERASE:   stb.erase   = 1'b1;
            default:    stb         = '0;
         endcase
      end
   end

   assign timed_wr = stb.cfg_wr | stb.sig_wr | stb.lock | stb.erase;

endmodule

// File: rtl/cfg_guard_lock.sv
module cfg_guard_lock #(
   parameter int WR_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_stb,
   input  logic erase_stb,
   input  logic timed_wr,
   output logic secured,
   output logic busy
);

   localparam int CNT_W = $clog2(WR_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES);

   if (WR_CYCLES < 1) begin : g_bad_cycles
      $error("WR_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_cnt <= '0;
      end else if (timed_wr) begin
         wait_cnt <= CNT_LOAD;
      end else if (wait_cnt != '0) begin
         wait_cnt <= wait_cnt - 1'b1;
      end
   end

   assign busy = (wait_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         secured <= 1'b0;
      end else if (erase_stb) begin
         secured <= 1'b0;
      end else if (lock_stb) begin
         secured <= 1'b1;
      end
   end

   assert_busy_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt <= CNT_LOAD);

   assert_busy_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
      timed_wr |=> (wait_cnt == CNT_LOAD));

   assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (secured && !erase_stb) |=> secured);

   assert_erase_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      erase_stb |=> !secured);

endmodule

// File: rtl/cfg_guard_store.sv
module cfg_guard_store #(
   parameter int CFG_WORDS = 8,
   parameter int SIG_BYTES = 8,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              sig_wr,
   input  logic              erase,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cfg_word,
   output logic [DATA_W-1:0] sig_byte
);

   localparam int CFG_IW = $clog2(CFG_WORDS);
   localparam int SIG_IW = $clog2(SIG_BYTES);
   localparam logic [ADDR_W:0] CFG_LIM = CFG_WORDS[ADDR_W:0];
   localparam logic [ADDR_W:0] SIG_LIM = SIG_BYTES[ADDR_W:0];

   if (CFG_WORDS < 2 || CFG_WORDS > (1 << ADDR_W)) begin : g_bad_cfg
      $error("CFG_WORDS must lie in 2 .. 2**ADDR_W");
   end
   if (SIG_BYTES < 2 || SIG_BYTES > (1 << ADDR_W)) begin : g_bad_sig
      $error("SIG_BYTES must lie in 2 .. 2**ADDR_W");
   end

   logic [DATA_W-1:0] cfg_q [CFG_WORDS];
   logic [DATA_W-1:0] sig_q [SIG_BYTES];
   logic              cfg_hit;
   logic              sig_hit;

   assign cfg_hit = ({1'b0, addr} < CFG_LIM);
   assign sig_hit = ({1'b0, addr} < SIG_LIM);

   for (genvar i = 0; i < CFG_WORDS; i++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[i] <= '0;
         end else if (erase) begin
            cfg_q[i] <= '0;
         end else if (cfg_wr && addr == ADDR_W'(i)) begin
            cfg_q[i] <= wdata;
         end
      end
   end

   for (genvar j = 0; j < SIG_BYTES; j++) begin : g_sig
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sig_q[j] <= '0;
         end else if (sig_wr && addr == ADDR_W'(j)) begin
            sig_q[j] <= wdata;
         end
      end
   end

   assign cfg_word = cfg_hit ? cfg_q[addr[CFG_IW-1:0]] : '0;
   assign sig_byte = sig_hit ? sig_q[addr[SIG_IW-1:0]] : '0;

   assert_erase_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> (cfg_word == '0));

   assert_sig_survives_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (erase && $stable(addr)) |=> $stable(sig_byte));

endmodule

// File: rtl/cfg_guard_preload.sv
module cfg_guard_preload #(
   parameter int REG_N  = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pre_stb,
   input  logic              secured,
   input  logic [ADDR_W-1:0] addr,
   input  logic              level,
   output logic [REG_N-1:0]  regs
);

   if (REG_N < 1 || REG_N > (1 << ADDR_W)) begin : g_bad_regs
      $error("REG_N must lie in 1 .. 2**ADDR_W");
   end

   logic allow;
   assign allow = pre_stb & ~secured;

   for (genvar k = 0; k < REG_N; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[k] <= 1'b0;
         end else if (allow && addr == ADDR_W'(k)) begin
            regs[k] <= level;
         end
      end
   end

   assert_preload_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_stb && secured) |=> $stable(regs));

   assert_preload_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(regs ^ $past(regs)) <= 1));

endmodule

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
   import cfg_guard_pkg::*;
#(
   parameter int CFG_WORDS = 8,
   parameter int SIG_BYTES = 8,
   parameter int REG_N     = 8,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int WR_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              busy,
   output logic              secured,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              denied,
   output logic [REG_N-1:0]  out_regs
);

   guard_stb_t        stb;
   logic              timed_wr;
   logic [DATA_W-1:0] cfg_word;
   logic [DATA_W-1:0] sig_byte;

   cfg_guard_decode u_decode (
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .busy      (busy),
      .stb       (stb),
      .timed_wr  (timed_wr)
   );

   cfg_guard_lock #(.WR_CYCLES(WR_CYCLES)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock_stb  (stb.lock),
      .erase_stb (stb.erase),
      .timed_wr  (timed_wr),
      .secured   (secured),
      .busy      (busy)
   );

   cfg_guard_store #(
      .CFG_WORDS (CFG_WORDS),
      .SIG_BYTES (SIG_BYTES),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (stb.cfg_wr),
      .sig_wr   (stb.sig_wr),
      .erase    (stb.erase),
      .addr     (cmd_addr),
      .wdata    (cmd_wdata),
      .cfg_word (cfg_word),
      .sig_byte (sig_byte)
   );

   cfg_guard_preload #(.REG_N(REG_N), .ADDR_W(ADDR_W)) u_preload (
      .clk     (clk),
      .rst_n   (rst_n),
      .pre_stb (stb.preload),
      .secured (secured),
      .addr    (cmd_addr),
      .level   (cmd_wdata[0]),
      .regs    (out_regs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         denied   <= 1'b0;
      end else begin
         rd_valid <= stb.cfg_vfy | stb.sig_rd;
         denied   <= (stb.cfg_vfy | stb.preload) & secured;
         if (stb.sig_rd) begin
            rd_data <= sig_byte;
         end else if (stb.cfg_vfy && !secured) begin
            rd_data <= cfg_word;
         end else begin
            rd_data <= '0;
         end
      end
   end

   assert_denied_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      denied |-> (rd_data == '0));

   assert_denied_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (denied && !$past(stb.cfg_vfy | stb.preload)) |-> 1'b0);

   assert_busy_freezes_regs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(out_regs));

   assert_busy_keeps_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(secured));

   assert_sig_never_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stb.sig_rd |=> (rd_valid && !denied));

endmodule

// File: tb/cfg_guard_ctrl_tb.sv
module cfg_guard_ctrl_tb_top;

   localparam int WRC = 4;
   localparam logic [2:0] C_WR = 3'd1, C_VF = 3'd2, C_PL = 3'd3, C_SW = 3'd4,
                          C_SR = 3'd5, C_LK = 3'd6, C_ER = 3'd7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [3:0] cmd_addr = '0;
   logic [7:0] cmd_wdata = '0;
   logic       busy, secured, rd_valid, denied;
   logic [7:0] rd_data, out_regs;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   cfg_guard_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
      .secured(secured), .rd_valid(rd_valid), .rd_data(rd_data),
      .denied(denied), .out_regs(out_regs)
   );

   // {op, addr, wdata, read_expected, rd_data, denied, secured, out_regs}
   localparam int NV = 22;
   localparam logic [33:0] VEC [NV] = '{
      {C_WR, 4'h2, 8'hA5, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},  // R3
      {C_WR, 4'h7, 8'h3C, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},  // R3
      {C_VF, 4'h2, 8'h00, 1'b1, 8'hA5, 1'b0, 1'b0, 8'h00},  // R3
      {C_VF, 4'h7, 8'h00, 1'b1, 8'h3C, 1'b0, 1'b0, 8'h00},  // R3
      {C_VF, 4'h0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00},  // R1
      {C_SW, 4'h1, 8'h5A, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00},  // R4
      {C_SR, 4'h1, 8'h00, 1'b1, 8'h5A, 1'b0, 1'b0, 8'h00},  // R4
      {C_PL, 4'h3, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0, 8'h08},  // R5
      {C_PL, 4'h0, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 8'h09},  // R5
      {C_PL, 4'h3, 8'hFE, 1'b0, 8'h00, 1'b0, 1'b0, 8'h01},  // R5
      {C_VF, 4'h9, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h01},  // R10
      {C_WR, 4'h9, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 8'h01},  // R10
      {C_LK, 4'h0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 8'h01},  // R6
      {C_VF, 4'h2, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, 8'h01},  // R7
      {C_PL, 4'h5, 8'h01, 1'b0, 8'h00, 1'b1, 1'b1, 8'h01},  // R8
      {C_SR, 4'h1, 8'h00, 1'b1, 8'h5A, 1'b0, 1'b1, 8'h01},  // R4
      {C_SW, 4'h2, 8'h77, 1'b0, 8'h00, 1'b0, 1'b1, 8'h01},  // R4
      {C_SR, 4'h2, 8'h00, 1'b1, 8'h77, 1'b0, 1'b1, 8'h01},  // R4
      {C_ER, 4'h0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 8'h01},  // R9
      {C_VF, 4'h2, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h01},  // R9
      {C_SR, 4'h1, 8'h00, 1'b1, 8'h5A, 1'b0, 1'b0, 8'h01},  // R9
      {C_PL, 4'h5, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0, 8'h21}   // R9
   };

   localparam string TAG [NV] = '{"R3","R3","R3","R3","R1","R4","R4","R5","R5","R5",
      "R10","R10","R6","R7","R8","R4","R4","R4","R9","R9","R9","R9"};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", 32'(busy), 0);
      check("R1 secured", 32'(secured), 0);
      check("R1 rd_valid", 32'(rd_valid), 0);
      check("R1 denied", 32'(denied), 0);
      check("R1 out_regs", 32'(out_regs), 0);

      for (int k = 0; k < NV; k++) begin
         issue(VEC[k][33:31], VEC[k][30:27], VEC[k][26:19]);
         check({TAG[k], " rd_valid"}, 32'(rd_valid), 32'(VEC[k][18]));
         if (VEC[k][18]) check({TAG[k], " rd_data"}, 32'(rd_data), 32'(VEC[k][17:10]));
         check({TAG[k], " denied"}, 32'(denied), 32'(VEC[k][9]));
         check({TAG[k], " secured"}, 32'(secured), 32'(VEC[k][8]));
         check({TAG[k], " out_regs"}, 32'(out_regs), 32'(VEC[k][7:0]));
         wait_idle();
      end

      // R2: busy length and a command dropped mid-write
      begin
         int n = 0;
         issue(C_WR, 4'h4, 8'h11);
         cmd_valid = 1'b1; cmd_op = C_WR; cmd_addr = 4'h4; cmd_wdata = 8'h22;
         @(negedge clk);
         cmd_valid = 1'b0;
         n = 1;
         while (busy) begin n++; @(negedge clk); end
         check("R2 busy cycles", 32'(n), WRC);
         issue(C_VF, 4'h4, 8'h00);
         check("R2 ignored while busy", 32'(rd_data), 32'h11);
      end

      // R2: lock presented while busy is ignored
      issue(C_SW, 4'h6, 8'h42);
      cmd_valid = 1'b1; cmd_op = C_LK;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_idle();
      check("R2 lock ignored", 32'(secured), 0);

      // R7: denied lasts one cycle
      issue(C_LK, 4'h0, 8'h00);
      wait_idle();
      issue(C_VF, 4'h4, 8'h00);
      check("R7 denied high", 32'(denied), 1);
      check("R7 blank data", 32'(rd_data), 0);
      @(negedge clk);
      check("R7 denied one cycle", 32'(denied), 0);

      // R10: out-of-range preload and signature access
      issue(C_ER, 4'h0, 8'h00);
      wait_idle();
      issue(C_SW, 4'hC, 8'h99);
      wait_idle();
      issue(C_SR, 4'hC, 8'h00);
      check("R10 sig out of range", 32'(rd_data), 0);
      issue(C_SR, 4'h6, 8'h00);
      check("R4 sig byte 6", 32'(rd_data), 32'h42);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule